// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into 30-bit physical addresses using 4 KB pages. It has 32 entries, and every entry is compared against the page number of an access in the same cycle. The entry's frame number replaces the upper address bits, and the 12-bit page offset passes through unchanged. Any address whose two top bits are both 1 skips the buffer: its low 30 bits are used directly as the physical address. A mapped access raises one of three faults. A miss means no entry matched. An invalid fault means the matching entry is not valid. A protection fault means a store hit an entry that forbids writes. Every fault records the full faulting address, and it records the page image in the key register so that software can refill the entry quickly.

Software manages the buffer through four registers: an index register, a key register holding the page number, a value register holding the frame and flags, and a fault-address register. It uses seven operation codes. Three of them load a register from a data word. The other four do the following:
- probe the entries with the key register;
- write to a pseudo-random entry;
- read the entry the index register selects;
- write the entry the index register selects.

A free-running counter picks the random slot. It skips the low four entries, so those entries can hold mappings that must stay fixed. Every operation is privileged. An operation issued in user mode only raises a privilege fault.

Top module: `xlat_buffer`

## Requirements
- R1: After reset the index, key, value and fault-address registers read 0, and no entry matches any page: a mapped access with `acc_valid` high raises `exc_miss`.
- R2: An access whose `acc_vaddr[31:30]` is `2'b11` raises no fault and yields `acc_paddr = acc_vaddr[29:0]`, whether it is a load or a store.
- R3: An access that hits a valid entry, with the store allowed, raises no fault and yields `acc_paddr = {frame, acc_vaddr[11:0]}`. The frame is bits 29:12 of the value image that was stored.
- R4: An access to a mapped page that matches no entry raises `exc_miss` only. At the next clock edge the key register becomes `{acc_vaddr[31:12], 12'h000}` and the fault-address register becomes `acc_vaddr`.
- R5: An access that hits an entry whose valid flag (value bit 0) is clear raises `exc_invalid` only, with the same register updates as R4.
- R6: A store that hits a valid entry whose write-enable flag (value bit 1) is clear raises `exc_wprot` only, with the same register updates as R4. A load from the same entry translates without a fault.
- R7: Probe (op 1) compares key bits 31:12 against all entries. On a hit the index register becomes the entry number. On no hit it becomes `32'h8000_0000`. A key whose top two bits are both 1 never hits.
- R8: Random write (op 2) stores the key and value images into the entry a counter selects. The counter moves by one every clock from 4 up to 31 and then wraps to 4. Entries 0 to 3 are never written this way.
- R9: Indexed read (op 3) loads the key register with `{page, 12'h000}` and the value register with `{2'b00, frame, 10'b0, write_enable, valid}`, both taken from the entry that index bits 4:0 select.
- R10: Indexed write (op 4) stores the key page and the value frame and flags into the entry that index bits 4:0 select, and later accesses translate through it.
- R11: The register loads work as follows:
  - op 5 sets the index register to `{d[31], 26'b0, d[4:0]}`;
  - op 6 sets the key register to `{d[31:12], 12'h000}`;
  - op 7 sets the value register to `{2'b00, d[29:12], 10'b0, d[1:0]}`.
  
  Op 0 does nothing.
- R12: Any non-zero op issued while `user_mode` is high raises `exc_priv` in that cycle and changes no register and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A translation is requested this cycle |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_store | input | 1 | The access is a store |
| user_mode | input | 1 | Processor is in user mode |
| op_code | input | 3 | Management operation, 0 = none |
| op_wdata | input | 32 | Data word for the register-load operations |
| acc_paddr | output | 30 | Translated physical address |
| exc_miss | output | 1 | No entry matched a mapped access |
| exc_invalid | output | 1 | The matching entry is not valid |
| exc_wprot | output | 1 | A store hit a write-protected entry |
| exc_priv | output | 1 | A management operation was issued in user mode |
| reg_index | output | 32 | Index register |
| reg_entry_hi | output | 32 | Key register (page image) |
| reg_entry_lo | output | 32 | Value register (frame and flags image) |
| reg_bad_addr | output | 32 | Last faulting virtual address |

## Verification
The assertions assume that software never leaves two entries holding the same page. They also assume that a faulting access and a management operation never fall in the same cycle, because the key register would then have two writers. The bench keeps every page number it writes unique, including those in the random-write sweep. It drives accesses and operations in separate cycles. The protection and privilege checks further assume that `acc_valid` is low whenever an operation is issued. The bench holds to that as well.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int VA_W   = 32;
  localparam int PA_W   = 30;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = PA_W - OFF_W;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROBE  = 3'd1,
    OP_WRAND  = 3'd2,
    OP_RDIDX  = 3'd3,
    OP_WRIDX  = 3'd4,
    OP_SETIDX = 3'd5,
    OP_SETHI  = 3'd6,
    OP_SETLO  = 3'd7
  } xlat_op_e;

  // true when an address lies in the untranslated window
  function automatic logic in_window(input logic [VA_W-1:0] va);
    return va[VA_W-1] & va[VA_W-2];
  endfunction

  // a stored page with both top bits set can never be matched
  function automatic logic key_usable(input logic [VPN_W-1:0] vpn);
    return !(vpn[VPN_W-1] & vpn[VPN_W-2]);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic [31:0] hi_image(input logic [VPN_W-1:0] vpn);
    return {vpn, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [31:0] lo_image(input logic [PFN_W-1:0] pfn,
                                           input logic wen, input logic vld);
    return {2'b00, pfn, 10'b0, wen, vld};
  endfunction

endpackage

// File: rtl/xlat_rand.sv
module xlat_rand #(
  parameter int N_ENTRIES  = 32,
  parameter int N_RESERVED = 4,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] rnd_idx
);
  localparam logic [IDX_W-1:0] LOW_SLOT  = IDX_W'(N_RESERVED);
  localparam logic [IDX_W-1:0] HIGH_SLOT = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             at_top;

  assign at_top  = (cnt_q == HIGH_SLOT);
  assign rnd_idx = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= LOW_SLOT;
    else if (at_top) cnt_q <= LOW_SLOT;
    else             cnt_q <= cnt_q + IDX_W'(1);
  end

  assert_rand_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_idx >= LOW_SLOT);

  assert_rand_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_idx == HIGH_SLOT) |=> (rnd_idx == LOW_SLOT));

  assert_rand_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_idx != HIGH_SLOT) |=> (rnd_idx == $past(rnd_idx) + IDX_W'(1)));

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  // access lookup port
  input  logic [VPN_W-1:0] acc_vpn,
  output logic             acc_hit,
  output logic [PFN_W-1:0] acc_pfn,
  output logic             acc_wen,
  output logic             acc_vld,
  // probe port
  input  logic [VPN_W-1:0] prb_vpn,
  output logic             prb_hit,
  output logic [IDX_W-1:0] prb_idx,
  // indexed read port
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PFN_W-1:0] rd_pfn,
  output logic             rd_wen,
  output logic             rd_vld,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_wen,
  input  logic             wr_vld
);
  localparam logic [VPN_W-1:0] DEAD_KEY = {2'b11, {(VPN_W-2){1'b0}}};

  logic [VPN_W-1:0] key_q [N_ENTRIES];
  logic [PFN_W-1:0] pfn_q [N_ENTRIES];
  logic             wen_q [N_ENTRIES];
  logic             vld_q [N_ENTRIES];

  logic [N_ENTRIES-1:0] acc_match;
  logic [N_ENTRIES-1:0] prb_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        key_q[i] <= DEAD_KEY;
        pfn_q[i] <= '0;
        wen_q[i] <= 1'b0;
        vld_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      key_q[wr_idx] <= wr_vpn;
      pfn_q[wr_idx] <= wr_pfn;
      wen_q[wr_idx] <= wr_wen;
      vld_q[wr_idx] <= wr_vld;
    end
  end

  // one comparator pair per entry, all evaluated in parallel
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign acc_match[g] = key_usable(key_q[g]) && (key_q[g] == acc_vpn);
    assign prb_match[g] = key_usable(key_q[g]) && (key_q[g] == prb_vpn);
  end

  assign acc_hit = |acc_match;
  assign prb_hit = |prb_match;

  // OR-merge: exact when at most one entry matches (software's duty)
  always_comb begin
    acc_pfn = '0;
    acc_wen = 1'b0;
    acc_vld = 1'b0;
    prb_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (acc_match[i]) begin
        acc_pfn = acc_pfn | pfn_q[i];
        acc_wen = acc_wen | wen_q[i];
        acc_vld = acc_vld | vld_q[i];
      end
      if (prb_match[i]) prb_idx = prb_idx | IDX_W'(i);
    end
  end

  assign rd_vpn = key_q[rd_idx];
  assign rd_pfn = pfn_q[rd_idx];
  assign rd_wen = wen_q[rd_idx];
  assign rd_vld = vld_q[rd_idx];

  // a written entry reads back what was written on the next cycle
  assert_wr_land_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> (rd_vpn == $past(wr_vpn) && rd_pfn == $past(wr_pfn)));

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES  = 32,
  parameter int N_RESERVED = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [31:0] acc_vaddr,
  input  logic        acc_store,
  input  logic        user_mode,
  input  logic [2:0]  op_code,
  input  logic [31:0] op_wdata,
  output logic [29:0] acc_paddr,
  output logic        exc_miss,
  output logic        exc_invalid,
  output logic        exc_wprot,
  output logic        exc_priv,
  output logic [31:0] reg_index,
  output logic [31:0] reg_entry_hi,
  output logic [31:0] reg_entry_lo,
  output logic [31:0] reg_bad_addr
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  xlat_op_e         op;
  logic             op_ok;
  logic             acc_mapped;
  logic             acc_fault;

  logic [31:0]      index_q, hi_q, lo_q, bad_q;

  logic [IDX_W-1:0] rnd_idx;
  logic             acc_hit, acc_wen, acc_vld;
  logic [PFN_W-1:0] acc_pfn;
  logic             prb_hit;
  logic [IDX_W-1:0] prb_idx;
  logic [VPN_W-1:0] rd_vpn;
  logic [PFN_W-1:0] rd_pfn;
  logic             rd_wen, rd_vld;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             probe_fire;

  logic unused_sink;
  assign unused_sink = ^{op_wdata[11:2], index_q[30:IDX_W]};

  assign op         = xlat_op_e'(op_code);
  assign exc_priv   = (op != OP_NONE) && user_mode;
  assign op_ok      = (op != OP_NONE) && !user_mode;
  assign probe_fire = op_ok && (op == OP_PROBE);

  xlat_rand #(.N_ENTRIES(N_ENTRIES), .N_RESERVED(N_RESERVED)) u_rand (
    .clk     (clk),
    .rst_n   (rst_n),
    .rnd_idx (rnd_idx)
  );

  assign wr_en  = op_ok && (op == OP_WRAND || op == OP_WRIDX);
  assign wr_idx = (op == OP_WRAND) ? rnd_idx : index_q[IDX_W-1:0];

  xlat_cam #(.N_ENTRIES(N_ENTRIES)) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_vpn (acc_vaddr[31:OFF_W]),
    .acc_hit (acc_hit),
    .acc_pfn (acc_pfn),
    .acc_wen (acc_wen),
    .acc_vld (acc_vld),
    .prb_vpn (hi_q[31:OFF_W]),
    .prb_hit (prb_hit),
    .prb_idx (prb_idx),
    .rd_idx  (index_q[IDX_W-1:0]),
    .rd_vpn  (rd_vpn),
    .rd_pfn  (rd_pfn),
    .rd_wen  (rd_wen),
    .rd_vld  (rd_vld),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_vpn  (hi_q[31:OFF_W]),
    .wr_pfn  (lo_q[PA_W-1:OFF_W]),
    .wr_wen  (lo_q[1]),
    .wr_vld  (lo_q[0])
  );

  // translation path
  assign acc_mapped  = acc_valid && !in_window(acc_vaddr);
  assign exc_miss    = acc_mapped && !acc_hit;
  assign exc_invalid = acc_mapped && acc_hit && !acc_vld;
  assign exc_wprot   = acc_mapped && acc_hit && acc_vld && acc_store && !acc_wen;
  assign acc_fault   = exc_miss || exc_invalid || exc_wprot;

  always_comb begin
    if (in_window(acc_vaddr)) acc_paddr = acc_vaddr[PA_W-1:0];
    else if (acc_hit)         acc_paddr = join_pa(acc_pfn, acc_vaddr[OFF_W-1:0]);
    else                      acc_paddr = '0;
  end

  // management registers; a translation fault wins over an op on the key
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      bad_q   <= '0;
    end else begin
      if (op_ok) begin
        case (op)
          OP_PROBE:  index_q <= prb_hit ? 32'(prb_idx) : 32'h8000_0000;
          OP_RDIDX: begin
            hi_q <= hi_image(rd_vpn);
            lo_q <= lo_image(rd_pfn, rd_wen, rd_vld);
          end
          OP_SETIDX: index_q <= {op_wdata[31], {(31-IDX_W){1'b0}}, op_wdata[IDX_W-1:0]};
          OP_SETHI:  hi_q    <= hi_image(op_wdata[31:OFF_W]);
          OP_SETLO:  lo_q    <= lo_image(op_wdata[PA_W-1:OFF_W], op_wdata[1], op_wdata[0]);
          default: ;
        endcase
      end
      if (acc_fault) begin
        hi_q  <= hi_image(acc_vaddr[31:OFF_W]);
        bad_q <= acc_vaddr;
      end
    end
  end

  assign reg_index    = index_q;
  assign reg_entry_hi = hi_q;
  assign reg_entry_lo = lo_q;
  assign reg_bad_addr = bad_q;

  assert_exc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_miss, exc_invalid, exc_wprot}));

  assert_window_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_window(acc_vaddr)) |-> !(exc_miss || exc_invalid || exc_wprot));

  assert_bad_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_miss || exc_invalid || exc_wprot) |=> (reg_bad_addr == $past(acc_vaddr)));

  assert_probe_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_fire && !prb_hit) |=> (reg_index == 32'h8000_0000));

  assert_priv_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_priv && !acc_valid) |=> ($stable(reg_index) && $stable(reg_entry_hi) && $stable(reg_entry_lo)));

endmodule

// File: tb/xlat_buffer_tb.sv
module xlat_buffer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_vaddr;
  logic        acc_store;
  logic        user_mode;
  logic [2:0]  op_code;
  logic [31:0] op_wdata;
  logic [29:0] acc_paddr;
  logic        exc_miss, exc_invalid, exc_wprot, exc_priv;
  logic [31:0] reg_index, reg_entry_hi, reg_entry_lo, reg_bad_addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xlat_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .acc_store(acc_store), .user_mode(user_mode), .op_code(op_code),
    .op_wdata(op_wdata), .acc_paddr(acc_paddr), .exc_miss(exc_miss),
    .exc_invalid(exc_invalid), .exc_wprot(exc_wprot), .exc_priv(exc_priv),
    .reg_index(reg_index), .reg_entry_hi(reg_entry_hi),
    .reg_entry_lo(reg_entry_lo), .reg_bad_addr(reg_bad_addr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // exceptions packed as {miss, invalid, wprot}
  function automatic logic [31:0] excs();
    return {29'b0, exc_miss, exc_invalid, exc_wprot};
  endfunction

  function automatic int step(input int x);
    return (x == 31) ? 4 : x + 1;
  endfunction

  // one-cycle operation: drive after the falling edge, let it land on the rising edge
  task automatic do_op(input logic [2:0] code, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    op_code   = code;
    op_wdata  = d;
    @(posedge clk);
    #1;
    op_code   = 3'd0;
  endtask

  // present an access; outputs are sampled before the edge that commits it
  task automatic access(input logic [31:0] va, input logic st,
                        output logic [29:0] pa, output logic [31:0] ex);
    @(negedge clk);
    op_code   = 3'd0;
    acc_valid = 1'b1;
    acc_vaddr = va;
    acc_store = st;
    #1;
    pa = acc_paddr;
    ex = excs();
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
  endtask

  task automatic put_entry(input int idx, input logic [31:0] hi, input logic [31:0] lo);
    do_op(3'd5, 32'(idx));
    do_op(3'd6, hi);
    do_op(3'd7, lo);
    do_op(3'd4, 32'h0);
  endtask

  task automatic t_reset();
    logic [29:0] pa; logic [31:0] ex;
    check("R1", "index",   reg_index,    32'h0);
    check("R1", "hi",      reg_entry_hi, 32'h0);
    check("R1", "lo",      reg_entry_lo, 32'h0);
    check("R1", "bad",     reg_bad_addr, 32'h0);
    access(32'h0000_1234, 1'b0, pa, ex);
    check("R1", "miss after reset", ex, 32'h4);
    do_op(3'd6, 32'hC000_0000);
    do_op(3'd1, 32'h0);
    check("R7", "dead key probe", reg_index, 32'h8000_0000);
  endtask

  task automatic t_window();
    logic [29:0] pa; logic [31:0] ex;
    access(32'hC001_2345, 1'b1, pa, ex);
    check("R2", "window paddr", 32'(pa), 32'h0001_2345);
    check("R2", "window exc",   ex, 32'h0);
    access(32'hFFFF_FFFF, 1'b0, pa, ex);
    check("R2", "window top paddr", 32'(pa), 32'h3FFF_FFFF);
    check("R2", "window top exc",   ex, 32'h0);
  endtask

  task automatic t_loads();
    do_op(3'd6, 32'h1234_5ABC);
    check("R11", "set hi",  reg_entry_hi, 32'h1234_5000);
    do_op(3'd7, 32'hFFFF_FFFF);
    check("R11", "set lo",  reg_entry_lo, 32'h3FFF_F003);
    do_op(3'd5, 32'h7FFF_FFE5);
    check("R11", "set idx", reg_index,    32'h0000_0005);
    do_op(3'd0, 32'hFFFF_FFFF);
    check("R11", "nop idx", reg_index,    32'h0000_0005);
  endtask

  task automatic t_write_index();
    logic [29:0] pa; logic [31:0] ex;
    put_entry(5, 32'h0040_0000, 32'h00AB_C003);
    access(32'h0040_0123, 1'b1, pa, ex);
    check("R10", "hit exc",   ex, 32'h0);
    check("R3",  "hit paddr", 32'(pa), 32'h00AB_C123);
    access(32'h0040_0FFF, 1'b0, pa, ex);
    check("R3",  "hit paddr top off", 32'(pa), 32'h00AB_CFFF);
  endtask

  task automatic t_read_index();
    do_op(3'd6, 32'h7777_7000);
    do_op(3'd7, 32'h0000_0000);
    do_op(3'd5, 32'h0000_0005);
    do_op(3'd3, 32'h0);
    check("R9", "read hi", reg_entry_hi, 32'h0040_0000);
    check("R9", "read lo", reg_entry_lo, 32'h00AB_C003);
  endtask

  task automatic t_miss();
    logic [29:0] pa; logic [31:0] ex;
    access(32'h0080_1ABC, 1'b0, pa, ex);
    check("R4", "miss exc", ex, 32'h4);
    check("R4", "miss hi",  reg_entry_hi, 32'h0080_1000);
    check("R4", "miss bad", reg_bad_addr, 32'h0080_1ABC);
  endtask

  task automatic t_invalid();
    logic [29:0] pa; logic [31:0] ex;
    put_entry(6, 32'h0090_0000, 32'h0005_5002);
    access(32'h0090_0010, 1'b0, pa, ex);
    check("R5", "invalid exc", ex, 32'h2);
    check("R5", "invalid hi",  reg_entry_hi, 32'h0090_0000);
    check("R5", "invalid bad", reg_bad_addr, 32'h0090_0010);
  endtask

  task automatic t_wprot();
    logic [29:0] pa; logic [31:0] ex;
    put_entry(7, 32'h00A0_0000, 32'h0006_6001);
    access(32'h00A0_0FFF, 1'b0, pa, ex);
    check("R6", "load exc",   ex, 32'h0);
    check("R6", "load paddr", 32'(pa), 32'h0006_6FFF);
    access(32'h00A0_0444, 1'b1, pa, ex);
    check("R6", "store exc", ex, 32'h1);
    check("R6", "store hi",  reg_entry_hi, 32'h00A0_0000);
    check("R6", "store bad", reg_bad_addr, 32'h00A0_0444);
  endtask

  task automatic t_probe();
    do_op(3'd6, 32'h00A0_0000);
    do_op(3'd1, 32'h0);
    check("R7", "probe hit",  reg_index, 32'h0000_0007);
    do_op(3'd6, 32'h0BAD_0000);
    do_op(3'd1, 32'h0);
    check("R7", "probe miss", reg_index, 32'h8000_0000);
  endtask

  task automatic t_user();
    logic [29:0] pa; logic [31:0] ex;
    do_op(3'd5, 32'h0000_0005);
    do_op(3'd6, 32'h0123_4000);
    @(negedge clk);
    user_mode = 1'b1;
    op_code   = 3'd6;
    op_wdata  = 32'hFFFF_F000;
    #1;
    check("R12", "priv flag", 32'(exc_priv), 32'h1);
    @(negedge clk);
    op_code   = 3'd4;
    @(negedge clk);
    op_code   = 3'd0;
    user_mode = 1'b0;
    #1;
    check("R12", "priv flag clear", 32'(exc_priv), 32'h0);
    check("R12", "hi kept", reg_entry_hi, 32'h0123_4000);
    access(32'h0040_0123, 1'b0, pa, ex);
    check("R12", "entry kept", 32'(pa), 32'h00AB_C123);
  endtask

  task automatic t_random();
    logic [29:0] pa; logic [31:0] ex;
    int prev;
    for (int i = 0; i < 4; i++)
      put_entry(i, 32'h0200_0000 + 32'(i << 12), 32'h0001_0003 + 32'(i << 12));
    prev = -1;
    for (int k = 0; k < 40; k++) begin
      int cur;
      do_op(3'd6, 32'h0300_0000 + 32'(k << 12));
      do_op(3'd2, 32'h0);
      do_op(3'd1, 32'h0);
      cur = int'(reg_index[4:0]);
      if (reg_index[31] || cur < 4)
        check("R8", "random slot range", reg_index, 32'h4);
      else if (prev >= 0)
        check("R8", "random slot step", 32'(cur), 32'(step(step(step(prev)))));
      prev = cur;
    end
    for (int i = 0; i < 4; i++) begin
      do_op(3'd6, 32'h0200_0000 + 32'(i << 12));
      do_op(3'd1, 32'h0);
      check("R8", "reserved kept", reg_index, 32'(i));
    end
    access(32'h0302_7ABC, 1'b0, pa, ex);
    check("R8", "last random exc", ex, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_vaddr = '0; acc_store = 1'b0;
    user_mode = 1'b0; op_code = 3'd0; op_wdata = '0;
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_window();
        t_loads();
        t_write_index();
        t_read_index();
        t_miss();
        t_invalid();
        t_wprot();
        t_probe();
        t_user();
        t_random();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule